// File: doc/BRIEF.md
# Reloading Cycle-Count Interrupt Timer

This block is a 16-bit down-counting interval timer clocked by the processor clock. A per-cycle qualifier, `tick`, marks the cycles that count. Software programs it through four write-only byte registers at consecutive addresses: a control register, a load register, and the two bytes of a 16-bit reload value. While the timer is enabled, each qualified cycle lowers the counter by one. When the counter is already at zero, the next qualified cycle refills it from the reload value instead. This gives a repeating period of reload+1 qualified cycles.

The interrupt output is a level, not a pulse. It is high whenever the timer is enabled and its counter sits at zero, so it stays up until software disables or reloads the timer, or until the next qualified cycle refills the counter. A write to the load register both copies the reload value into the counter and stops the timer, so the usual arming sequence is: write the two reload bytes, write the load register, then enable through the control register. Register writes are plain strobes. They have no handshake and always complete in one cycle.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the counter and the reload value are zero, the timer is disabled and `irq` is low.
- R2: A write to address BASE+2 (default 0x9005) replaces the upper byte of the reload value and keeps its lower byte.
- R3: A write to address BASE+3 (default 0x9006) replaces the lower byte of the reload value and keeps its upper byte.
- R4: A write to address BASE (default 0x9003) takes the enable from data bit 7 and ignores the other data bits.
  - Writing enable 0 also clears the counter to zero.
  - Writing enable 1 leaves the counter unchanged.
- R5: A write to address BASE+1 (default 0x9004) copies the reload value into the counter and disables the timer, whatever the data.
- R6: On a cycle with `tick` high, the timer enabled, no register write and a nonzero counter, the counter drops by one.
- R7: On a cycle with `tick` high, the timer enabled, no register write and the counter at zero, the counter is refilled from the reload value. With a reload value of zero, the counter therefore stays at zero.
- R8: On a cycle with `tick` high while the timer is disabled, neither the counter, the reload value nor the enable changes.
- R9: `irq` is high exactly when the timer is enabled and the counter is zero. It is derived only from registered state, so it has no glitches within a cycle.
- R10: A register write to any of the four addresses in the same cycle as `tick` takes priority. That cycle's decrement or refill does not happen.
- R11: Writes to any address outside the four registers change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Qualifies this clock cycle as a counting cycle |
| irq | output | 1 | Level interrupt request |

## Verification
A register write and a counting cycle can land in the same clock cycle. The bench provokes this by raising `wr_en` and `tick` together in three situations:
- a control write while the counter is nonzero;
- a reload-byte write while the counter is nonzero;
- a reload-byte write while the counter sits at zero with `irq` high.

The outcome is judged at the `irq` pin. Had the tick been honoured, `irq` would show an extra refill immediately, or the count to the next interrupt would come out one cycle short. Since the write takes priority, the bench expects neither.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_LOAD = 3'd2,
    SEL_HI   = 3'd3,
    SEL_LO   = 3'd4
  } irqt_sel_e;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_LOAD = 1;
  localparam int unsigned OFS_HI   = 2;
  localparam int unsigned OFS_LO   = 3;

endpackage

// File: rtl/irqt_decode.sv
module irqt_decode
  import irqt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h9003
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output irqt_sel_e         sel
);

  localparam logic [ADDR_W-1:0] A_CTRL = BASE + ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD = BASE + ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_HI   = BASE + ADDR_W'(OFS_HI);
  localparam logic [ADDR_W-1:0] A_LO   = BASE + ADDR_W'(OFS_LO);

  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == A_CTRL)      sel = SEL_CTRL;
      else if (wr_addr == A_LOAD) sel = SEL_LOAD;
      else if (wr_addr == A_HI)   sel = SEL_HI;
      else if (wr_addr == A_LO)   sel = SEL_LO;
    end
  end

endmodule

// File: rtl/irqt_reload.sv
module irqt_reload
  import irqt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqt_sel_e         sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  rld
);

  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    localparam irqt_sel_e LANE_SEL = (gi == 1) ? SEL_HI : SEL_LO;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               byte_q <= '0;
      else if (sel == LANE_SEL) byte_q <= wr_data;
    end

    assign rld[gi*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/irqt_core.sv
module irqt_core
  import irqt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W  = 2 * DATA_W,
  localparam int unsigned EN_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqt_sel_e         sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic [CNT_W-1:0]  rld,
  output logic              en,
  output logic [CNT_W-1:0]  cnt
);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else begin
      case (sel)
        SEL_CTRL: begin
          en <= wr_data[EN_BIT];
          if (!wr_data[EN_BIT]) cnt <= '0;
        end
        SEL_LOAD: begin
          en  <= 1'b0;
          cnt <= rld;
        end
        SEL_HI, SEL_LO: ;
        default: begin
          if (tick && en) cnt <= at_zero ? rld : cnt - CNT_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import irqt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h9003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              irq
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  irqt_sel_e        sel;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  irqt_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel     (sel)
  );

  irqt_reload #(.DATA_W(DATA_W)) u_rld (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr_data (wr_data),
    .rld     (rld_q)
  );

  irqt_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr_data (wr_data),
    .tick    (tick),
    .rld     (rld_q),
    .en      (en_q),
    .cnt     (cnt_q)
  );

  assign irq = en_q & ~|cnt_q;

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h9003,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic              irq,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  rld
);

  logic hit, quiet;
  assign hit   = wr_en && (wr_addr >= BASE) && (wr_addr <= BASE + ADDR_W'(3));
  assign quiet = !(wr_en && hit);

  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && quiet) |=> ($stable(cnt) && $stable(rld) && !en));

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && quiet && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && quiet && cnt == '0) |=> (cnt == $past(rld)));

  p_load_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BASE + ADDR_W'(1)) |=> (!en && cnt == $past(rld)));

  p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BASE && !wr_data[DATA_W-1]) |=> (!en && cnt == '0));

  p_byte_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == BASE + ADDR_W'(2) || wr_addr == BASE + ADDR_W'(3)))
      |=> ($stable(cnt) && $stable(en)));

  p_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit && !tick) |=> ($stable(rld) && $stable(cnt) && $stable(en)));

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick(tick), .irq(irq),
  .en(en_q), .cnt(cnt_q), .rld(rld_q)
);

// File: tb/cyc_irq_timer_tb.sv
`timescale 1ns/1ps
module cyc_irq_timer_tb;

  localparam logic [15:0] A_CTRL = 16'h9003;
  localparam logic [15:0] A_LOAD = 16'h9004;
  localparam logic [15:0] A_HI   = 16'h9005;
  localparam logic [15:0] A_LO   = 16'h9006;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  cyc_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock cycle, called and returning at a falling edge
  task automatic cyc(input logic w, input logic [15:0] a, input logic [7:0] d, input logic t);
    wr_en = w; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b1);
  endtask

  task automatic ticks_to_irq(output int n, input int lim);
    n = 0;
    while (!irq && n < lim) begin
      cyc(1'b0, 16'h0, 8'h0, 1'b1);
      n++;
    end
  endtask

  task automatic arm(input logic [15:0] v);
    wr(A_HI, v[15:8]);
    wr(A_LO, v[7:0]);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'h80);
  endtask

  task automatic t_reset;
    chk(irq == 1'b0, "R1 irq low after reset", irq, 0);
    wr(A_CTRL, 8'h80);
    chk(irq == 1'b1, "R1 R9 counter zero after reset", irq, 1);
    ticks(1);
    chk(irq == 1'b1, "R1 R7 reload zero keeps counter zero", irq, 1);
    wr(A_CTRL, 8'h00);
    chk(irq == 1'b0, "R9 disabled drops irq", irq, 0);
  endtask

  task automatic t_bytes;
    int n;
    arm(16'h0003);
    chk(irq == 1'b0, "R5 R9 loaded nonzero counter", irq, 0);
    ticks_to_irq(n, 1000);
    chk(n == 3, "R3 R6 ticks to zero for 0x0003", n, 3);
    wr(A_HI, 8'h01);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'h80);
    ticks_to_irq(n, 1000);
    chk(n == 259, "R2 upper byte kept lower byte", n, 259);
    wr(A_LO, 8'h02);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'h80);
    ticks_to_irq(n, 1000);
    chk(n == 258, "R3 lower byte kept upper byte", n, 258);
  endtask

  task automatic t_refill;
    int n;
    arm(16'h0002);
    ticks_to_irq(n, 100);
    chk(n == 2, "R6 first period", n, 2);
    ticks(1);
    chk(irq == 1'b0, "R7 refill raises counter", irq, 0);
    ticks_to_irq(n, 100);
    chk(n == 2, "R7 period after refill", n, 2);
  endtask

  task automatic t_disabled;
    int n;
    wr(A_HI, 8'h00);
    wr(A_LO, 8'h04);
    wr(A_LOAD, 8'h00);
    ticks(10);
    chk(irq == 1'b0, "R8 disabled no irq", irq, 0);
    wr(A_CTRL, 8'h80);
    ticks_to_irq(n, 100);
    chk(n == 4, "R8 counter untouched while disabled", n, 4);
  endtask

  task automatic t_ctrl;
    int n;
    arm(16'h0004);
    ticks(2);
    wr(A_CTRL, 8'h00);
    chk(irq == 1'b0, "R4 disable", irq, 0);
    wr(A_CTRL, 8'h80);
    chk(irq == 1'b1, "R4 disable cleared counter", irq, 1);
    wr(A_CTRL, 8'h7F);
    chk(irq == 1'b0, "R4 only bit 7 enables", irq, 0);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'hFF);
    ticks(1);
    wr(A_CTRL, 8'h80);
    ticks_to_irq(n, 100);
    chk(n == 3, "R4 enable keeps counter", n, 3);
  endtask

  task automatic t_load;
    int n;
    arm(16'h0003);
    ticks_to_irq(n, 100);
    wr(A_LOAD, 8'hFF);
    chk(irq == 1'b0, "R5 load disables", irq, 0);
    ticks(5);
    wr(A_CTRL, 8'h80);
    ticks_to_irq(n, 100);
    chk(n == 3, "R5 load copied reload", n, 3);
  endtask

  task automatic t_collide;
    int n;
    arm(16'h0003);
    cyc(1'b1, A_CTRL, 8'h80, 1'b1);
    cyc(1'b1, A_HI, 8'h00, 1'b1);
    ticks_to_irq(n, 100);
    chk(n == 3, "R10 writes suppress tick", n, 3);
    cyc(1'b1, A_LO, 8'h03, 1'b1);
    chk(irq == 1'b1, "R10 no refill under write", irq, 1);
  endtask

  task automatic t_outside;
    int n;
    arm(16'h0002);
    ticks_to_irq(n, 100);
    wr(16'h9002, 8'h00);
    wr(16'h9007, 8'h00);
    wr(16'h1003, 8'h00);
    wr(16'h8004, 8'h00);
    chk(irq == 1'b1, "R11 outside writes keep state", irq, 1);
    wr(16'h1005, 8'h40);
    ticks(1);
    ticks_to_irq(n, 1000);
    chk(n == 2, "R11 reload unchanged", n, 2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_refill();
    t_disabled();
    t_ctrl();
    t_load();
    t_collide();
    t_outside();
    finish_run();
  end

endmodule